// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is a register file for a processor whose procedures each see thirty-two logical registers. Logical registers 0 to 9 are globals that every procedure shares. Logical registers 10 to 31 form a 22-register window taken from a circular ring of 128 physical registers. A call moves the window up by 16 physical registers, so the six highest registers of the caller (logical 26..31) become the six lowest registers of the callee (logical 10..15). Arguments and results therefore pass between procedures without any copying. A return moves the window back down. The file has 138 physical registers in total. It has two combinational read ports and one write port that takes effect on the clock edge.

A small state machine tracks how many windows are resident in hardware, from one up to eight. It has three states: `WS_BASE` (one resident window), `WS_NESTED` (two to seven) and `WS_FULL` (eight). The transitions are as follows:
- A call moves `WS_BASE` to `WS_NESTED`, or to `WS_FULL` when the eighth window is entered.
- A call moves `WS_NESTED` to `WS_FULL` when the eighth window is entered, and otherwise keeps it in `WS_NESTED`.
- A return moves `WS_NESTED` back to `WS_BASE` when one window remains, and otherwise keeps it in `WS_NESTED`.
- A return moves `WS_FULL` to `WS_NESTED`.

A call in `WS_FULL` raises the overflow trap. A return in `WS_BASE` raises the underflow trap. In both cases the window does not move. Saving and restoring windows is left to trap software outside this block.

Top module: `win_regfile`

## Requirements
- R1: After reset every logical register reads 0, both traps are low, and the current window is window 0 with one window resident.
- R2: Logical register 0 always reads 0 on both read ports, and a write to it has no effect.
- R3: Logical registers 1..9 address the same storage in every window, so a value written to them in any window reads back unchanged in every other window.
- R4: A call with one to seven windows resident moves to the next window. Afterwards the new logical registers 10..15 read the values that the caller had in its logical registers 26..31.
- R5: A return with two or more windows resident moves back to the previous window. The caller then reads its logical registers 10..31 exactly as it left them, apart from logical 26..31, which show what the callee wrote to its logical 10..15.
- R6: Logical registers 16..25 are private to a window: a write to them in one window never changes what any other window reads.
- R7: A call while eight windows are resident raises the overflow trap in the same cycle and leaves the window, the resident count and all register contents unchanged.
- R8: A return while one window is resident raises the underflow trap in the same cycle and leaves the window and all register contents unchanged.
- R9: A read of the register being written in the same cycle returns the old value; the new value is readable from the next cycle.
- R10: A call and a return asserted in the same cycle move nothing and raise no trap.
- R11: Window numbers wrap modulo 8, so logical registers 26..31 of window 7 are the same storage as logical registers 10..15 of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Enter a new window at the next edge |
| ret_i | input | 1 | Go back to the previous window at the next edge |
| rd_a_addr | input | ADDR_W (5) | Logical register for read port A |
| rd_a_data | output | DATA_W (32) | Combinational read data, port A |
| rd_b_addr | input | ADDR_W (5) | Logical register for read port B |
| rd_b_data | output | DATA_W (32) | Combinational read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W (5) | Logical register to write, decoded in the current window |
| wr_data | input | DATA_W (32) | Write data |
| ovf_trap | output | 1 | Call refused, all hardware windows occupied |
| unf_trap | output | 1 | Return refused, caller window not resident |

## Verification
The hardest state to reach is the full stack with the window at position 7. Only there does the overflow trap fire, and only there do a window's outgoing registers alias the incoming registers of window 0. The stimulus reaches this state with seven consecutive calls. At every depth it fills every windowed register with a value that encodes window and register, so each later readback shows which window last wrote that storage. It then unwinds with seven returns, checking all 32 logical registers on both ports after each move against a physical model computed in the bench.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;

    // Occupancy of the hardware window stack
    typedef enum logic [1:0] {
        WS_BASE   = 2'd0,   // only the current window is resident
        WS_NESTED = 2'd1,   // between two and NUM_WIN-1 windows resident
        WS_FULL   = 2'd2    // every hardware window holds a live frame
    } win_state_e;

endpackage

// File: rtl/wrf_addr_map.sv
`timescale 1ns/1ps
// Translates a logical register number into a physical storage index.
module wrf_addr_map #(
    parameter int NUM_GLOBALS = 10,
    parameter int NUM_WIN     = 8,
    parameter int WIN_UNIQUE  = 16,
    parameter int ADDR_W      = 5,
    parameter int PTR_W       = 3,
    parameter int PHYS_W      = 8
) (
    input  logic [ADDR_W-1:0] lreg,
    input  logic [PTR_W-1:0]  cwp,
    output logic [PHYS_W-1:0] preg
);

    localparam int RING = NUM_WIN * WIN_UNIQUE;

    int offs;
    int lin;

    always_comb begin
        offs = 0;
        lin  = 0;
        if (int'(lreg) < NUM_GLOBALS) begin
            preg = PHYS_W'(lreg);
        end else begin
            offs = int'(lreg) - NUM_GLOBALS;
            lin  = int'(cwp) * WIN_UNIQUE + offs;
            if (lin >= RING) begin
                lin = lin - RING;
            end
            preg = PHYS_W'(NUM_GLOBALS + lin);
        end
    end

endmodule

// File: rtl/wrf_storage.sv
`timescale 1ns/1ps
// Physical register array: entry 0 is a constant zero, the rest are flops.
module wrf_storage #(
    parameter int PHYS_REGS = 138,
    parameter int PHYS_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PHYS_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [PHYS_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs [PHYS_REGS];

    assign regs[0] = '0;

    for (genvar i = 1; i < PHYS_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (waddr == PHYS_W'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_a = (int'(raddr_a) < PHYS_REGS) ? regs[raddr_a] : '0;
        rdata_b = (int'(raddr_b) < PHYS_REGS) ? regs[raddr_b] : '0;
    end

endmodule

// File: rtl/wrf_window_ctrl.sv
`timescale 1ns/1ps
// Window pointer and resident-window state machine.
module wrf_window_ctrl
    import wrf_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int PTR_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [PTR_W-1:0] cwp,
    output logic             ovf_trap,
    output logic             unf_trap
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_WIN);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] count_up, count_dn;
    logic [PTR_W-1:0] cwp_d;
    logic             push, pop;

    assign push     = call_i & ~ret_i;
    assign pop      = ret_i & ~call_i;
    assign count_up = count_q + CNT_W'(1);
    assign count_dn = count_q - CNT_W'(1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        cwp_d   = cwp;
        unique case (state_q)
            WS_BASE: begin
                if (push) begin
                    count_d = count_up;
                    cwp_d   = cwp + PTR_W'(1);
                    state_d = (count_up == CNT_FULL) ? WS_FULL : WS_NESTED;
                end
            end
            WS_NESTED: begin
                if (push) begin
                    count_d = count_up;
                    cwp_d   = cwp + PTR_W'(1);
                    state_d = (count_up == CNT_FULL) ? WS_FULL : WS_NESTED;
                end else if (pop) begin
                    count_d = count_dn;
                    cwp_d   = cwp - PTR_W'(1);
                    state_d = (count_dn == CNT_ONE) ? WS_BASE : WS_NESTED;
                end
            end
            WS_FULL: begin
                if (pop) begin
                    count_d = count_dn;
                    cwp_d   = cwp - PTR_W'(1);
                    state_d = (count_dn == CNT_ONE) ? WS_BASE : WS_NESTED;
                end
            end
            default: begin
                state_d = WS_BASE;
                count_d = CNT_ONE;
                cwp_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_BASE;
            count_q <= CNT_ONE;
            cwp     <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            cwp     <= cwp_d;
        end
    end

    // Outputs
    always_comb begin
        ovf_trap = (state_q == WS_FULL) && push;
        unf_trap = (state_q == WS_BASE) && pop;
    end

endmodule

// File: rtl/win_regfile.sv
`timescale 1ns/1ps
// Register file with globals and a ring of overlapping procedure windows.
module win_regfile #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int NUM_GLOBALS = 10,
    parameter int NUM_WIN     = 8,
    parameter int WIN_UNIQUE  = 16,
    parameter int WIN_OVERLAP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ovf_trap,
    output logic              unf_trap
);

    localparam int WIN_SIZE  = WIN_UNIQUE + WIN_OVERLAP;
    localparam int LOG_REGS  = NUM_GLOBALS + WIN_SIZE;
    localparam int PHYS_REGS = NUM_GLOBALS + NUM_WIN * WIN_UNIQUE;
    localparam int PHYS_W    = $clog2(PHYS_REGS);
    localparam int PTR_W     = $clog2(NUM_WIN);
    localparam int CNT_W     = $clog2(NUM_WIN + 1);
    localparam int NPORT     = 3;   // read A, read B, write

    initial begin
        if (LOG_REGS != (1 << ADDR_W)) $error("logical register count must fill the address space");
    end

    logic [PTR_W-1:0]  cwp;
    logic [ADDR_W-1:0] lsel [NPORT];
    logic [PHYS_W-1:0] psel [NPORT];

    assign lsel[0] = rd_a_addr;
    assign lsel[1] = rd_b_addr;
    assign lsel[2] = wr_addr;

    wrf_window_ctrl #(
        .NUM_WIN (NUM_WIN),
        .PTR_W   (PTR_W),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .cwp      (cwp),
        .ovf_trap (ovf_trap),
        .unf_trap (unf_trap)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_addr_map #(
            .NUM_GLOBALS (NUM_GLOBALS),
            .NUM_WIN     (NUM_WIN),
            .WIN_UNIQUE  (WIN_UNIQUE),
            .ADDR_W      (ADDR_W),
            .PTR_W       (PTR_W),
            .PHYS_W      (PHYS_W)
        ) u_map (
            .lreg (lsel[p]),
            .cwp  (cwp),
            .preg (psel[p])
        );
    end

    wrf_storage #(
        .PHYS_REGS (PHYS_REGS),
        .PHYS_W    (PHYS_W),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (psel[2]),
        .wdata   (wr_data),
        .raddr_a (psel[0]),
        .rdata_a (rd_a_data),
        .raddr_b (psel[1]),
        .rdata_b (rd_b_data)
    );

endmodule

// File: rtl/wrf_checker.sv
`timescale 1ns/1ps
// Temporal checks on the window controller.
module wrf_checker #(
    parameter int NUM_WIN = 8,
    parameter int PTR_W   = 3,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_i,
    input logic             ret_i,
    input logic             ovf_trap,
    input logic             unf_trap,
    input logic [PTR_W-1:0] cwp,
    input logic [CNT_W-1:0] count_q
);

    // R1
    resident_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q >= CNT_W'(1)) && (count_q <= CNT_W'(NUM_WIN)));

    // R4
    call_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !ovf_trap) |=> (cwp == $past(cwp) + PTR_W'(1)));

    // R5
    ret_retreat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !unf_trap) |=> (cwp == $past(cwp) - PTR_W'(1)));

    // R7
    no_overflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |=> $stable(cwp));

    // R7
    overflow_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> (count_q == CNT_W'(NUM_WIN)));

    // R8
    no_underflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |=> $stable(cwp));

    // R8
    underflow_when_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> (count_q == CNT_W'(1)));

    // R10
    both_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |-> (!ovf_trap && !unf_trap));

    // R10
    both_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp));

    // R7
    trap_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap, unf_trap}));

endmodule

bind wrf_window_ctrl wrf_checker #(
    .NUM_WIN (NUM_WIN),
    .PTR_W   (PTR_W),
    .CNT_W   (CNT_W)
) u_wrf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .ovf_trap (ovf_trap),
    .unf_trap (unf_trap),
    .cwp      (cwp),
    .count_q  (count_q)
);

// File: tb/test_win_regfile.sv
`timescale 1ns/1ps
module test_win_regfile;

    localparam int NG    = 10;
    localparam int NW    = 8;
    localparam int UNIQ  = 16;
    localparam int NPHYS = NG + NW * UNIQ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0, wr_en = 1'b0;
    logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        ovf_trap, unf_trap;

    always #4 clk = ~clk;   // 125 MHz

    win_regfile i_win_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .rd_a_addr (rd_a_addr),
        .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ovf_trap  (ovf_trap),
        .unf_trap  (unf_trap)
    );

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] mdl [NPHYS];
    int          cur_w = 0;
    int          cur_n = 1;
    int          seq   = 0;
    logic [31:0] saved_out7;

    function automatic int phys(input int w, input int r);
        if (r < NG) return r;
        return NG + ((w * UNIQ + (r - NG)) % (NW * UNIQ));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Compare all 32 logical registers on both ports against the model
    task automatic check_all(input string req);
        for (int r = 0; r < 32; r++) begin
            rd_a_addr = 5'(r);
            rd_b_addr = 5'(31 - r);
            #1;
            chk(rd_a_data === mdl[phys(cur_w, r)], req, $sformatf("portA w%0d r%0d", cur_w, r),
                rd_a_data, mdl[phys(cur_w, r)]);
            chk(rd_b_data === mdl[phys(cur_w, 31 - r)], req, $sformatf("portB w%0d r%0d", cur_w, 31 - r),
                rd_b_data, mdl[phys(cur_w, 31 - r)]);
        end
    endtask

    // One clock cycle of stimulus with trap and read-during-write checks
    task automatic step(input bit c, input bit r, input bit we, input int wa,
                        input logic [31:0] wd, input string req);
        bit          e_ovf, e_unf;
        logic [31:0] old_v;
        @(negedge clk);
        call_i = c; ret_i = r; wr_en = we;
        wr_addr = 5'(wa); wr_data = wd; rd_a_addr = 5'(wa);
        e_ovf = c && !r && (cur_n == NW);
        e_unf = r && !c && (cur_n == 1);
        #1;
        chk(ovf_trap === e_ovf, req, "ovf_trap", 32'(ovf_trap), 32'(e_ovf));
        chk(unf_trap === e_unf, req, "unf_trap", 32'(unf_trap), 32'(e_unf));
        if (we) begin
            old_v = mdl[phys(cur_w, wa)];
            chk(rd_a_data === old_v, "R9", $sformatf("old value on write r%0d", wa), rd_a_data, old_v);
        end
        @(posedge clk);
        #1;
        if (we && wa != 0) mdl[phys(cur_w, wa)] = wd;
        if (c && !r && cur_n < NW) begin
            cur_w = (cur_w + 1) % NW; cur_n++;
        end else if (r && !c && cur_n > 1) begin
            cur_w = (cur_w + NW - 1) % NW; cur_n--;
        end
        call_i = 0; ret_i = 0; wr_en = 0;
        if (we) begin
            #1;
            chk(rd_a_data === mdl[phys(cur_w, wa)], "R9", $sformatf("new value r%0d", wa),
                rd_a_data, mdl[phys(cur_w, wa)]);
        end
    endtask

    task automatic fill(input int lo, input int hi, input string req);
        for (int r = lo; r <= hi; r++) begin
            seq++;
            step(0, 0, 1, r, {8'(cur_w), 8'(r), 16'(seq * 37)}, req);
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NPHYS; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(ovf_trap === 1'b0, "R1", "ovf after reset", 32'(ovf_trap), 0);
        chk(unf_trap === 1'b0, "R1", "unf after reset", 32'(unf_trap), 0);
        check_all("R1");

        // R2: register zero ignores writes; R3 globals written in window 0
        fill(0, 31, "R2");
        check_all("R2");

        // R4, R6, R3: descend through all hardware windows
        for (int d = 1; d < NW; d++) begin
            step(1, 0, 0, 0, '0, "R4");
            check_all("R4");
            fill(16, 31, "R6");
            seq++;
            step(0, 0, 1, 1 + (d % 9), {8'hC0, 8'(d), 16'(seq)}, "R3");
            check_all("R6");
        end
        saved_out7 = mdl[phys(7, 26)];

        // R7: overflow with all windows resident
        step(1, 0, 0, 0, '0, "R7");
        check_all("R7");

        // R10: call and return together
        step(1, 1, 0, 0, '0, "R10");
        check_all("R10");

        // R9: write and read the same register at depth
        step(0, 0, 1, 20, 32'hDEAD_0020, "R9");

        // R5: unwind back to window 0
        for (int d = 0; d < NW - 1; d++) begin
            step(0, 1, 0, 0, '0, "R5");
            check_all("R5");
        end

        // R11: window 7 outs alias window 0 ins
        rd_a_addr = 5'd10;
        #1;
        chk(rd_a_data === saved_out7, "R11", "w0 r10 vs w7 r26", rd_a_data, saved_out7);

        // R8: underflow at the base window
        step(0, 1, 0, 0, '0, "R8");
        check_all("R8");

        // R10 at base: both asserted, no underflow
        step(1, 1, 0, 0, '0, "R10");
        check_all("R10");

        summary();
        $finish;
    end

endmodule